// File: doc/BRIEF.md
# Shadowed Display Configuration Bank with Frame-Boundary Commit

This block holds the configuration words of a display engine in two copies. Software writes and reads a shadow copy through a simple 32-bit register port. The pixel pipeline sees only the active copy. The whole shadow copy moves into the active copy in a single clock cycle, and only when a vertical blanking interval begins. A frame therefore never shows half of an update.

A control word selects how transfers happen. In the default manual mode, software sets a request bit. The block copies the shadow words at the next blanking start and then clears the bit, so software can poll the bit to learn that the copy has happened. In automatic mode, a copy happens at the start of every blanking interval. The blanking input may be asynchronous: the block synchronises it and acts on its rising edge only.

The control word is at byte address 0x000. Bit 0 is the load request and bit 1 disables automatic mode. Configuration word i is at byte address CFG_BASE + 4*i, with a default CFG_BASE of 0x800. Addresses are byte addresses on a 4-byte stride inside a 15-bit space.

Top module: `dbc_top`

## Requirements
- R1: After reset, every shadow and active word is zero, the load request bit is 0 and the automatic-disable bit is 1, so the control word reads 0x2 and commit_pulse is low.
- R2: A write to configuration address CFG_BASE+4*i updates shadow word i, and a read of that address returns it. active_cfg does not change until a transfer occurs.
- R3: With automatic mode off and the load request bit clear, the start of a blanking interval leaves active_cfg unchanged and produces no commit_pulse.
- R4: With the load request bit set, commit_pulse goes high for exactly one cycle after the second rising clock edge that samples vblank_i high. On the third such edge, every active word takes its shadow value.
- R5: The load request bit reads 1 from the write that sets it until the edge on which the transfer happens, and it reads 0 from then on.
- R6: With automatic mode on (control bit 1 = 0), a transfer happens at every blanking start, whether or not the load request bit is set.
- R7: A vblank_i held high gives exactly one transfer, and its falling edge gives none.
- R8: A control write with bit 0 set in the cycle where commit_pulse is high leaves the request bit set. That request is served at the next blanking start.
- R9: Writing 0 to bit 0 of the control word does not withdraw a pending request. Bit 1 takes the written value.
- R10: A write to a misaligned address, or to an address that is neither the control word nor a configuration word, changes no state, and a read from such an address returns 0.
- R11: A shadow write in the transfer cycle lands in the shadow copy, while the active copy takes the value the shadow held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vblank_i | input | 1 | Vertical blanking level, may be asynchronous |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 15 | Byte address for both write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr (combinational) |
| active_cfg | output | 256 | Active copy, word i at bits [32*i+31:32*i] |
| commit_pulse | output | 1 | High in the one cycle in which a transfer happens |

## Verification
The port is first driven with a sequence of writes and read-backs. These include aligned words, a misaligned address, an address just past the last word and an unused address. Together they separate correct decoding from aliasing and from writes that leak into a real word.

Blanking edges are then applied in several states: no request, a pending request, automatic mode, a held-high level, and writes that land exactly in the transfer cycle. These cases distinguish a missing transfer from a spurious one, and an edge-triggered transfer from one triggered by the level. They also show whether a request in the transfer cycle is kept or lost, and whether the active copy takes the shadow value from before or after a same-cycle write.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  localparam int CTRL_LOAD_BIT    = 0;
  localparam int CTRL_AUTODIS_BIT = 1;

  typedef struct packed {
    logic is_ctrl;
    logic is_cfg;
  } dbc_sel_t;
endpackage

// File: rtl/dbc_vblank_sync.sv
module dbc_vblank_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vblank_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[SYNC_STAGES-1:0], vblank_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  // R7: a blanking start is a single-cycle event
  assert_single_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dbc_addr_decode.sv
module dbc_addr_decode
  import dbc_pkg::*;
#(
  parameter int              ADDR_W    = 15,
  parameter int              NUM_REGS  = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] CFG_BASE  = 15'h0800,
  localparam int             IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output dbc_sel_t          sel_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W:0] CFG_END = {1'b0, CFG_BASE} + (ADDR_W+1)'(4 * NUM_REGS);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off          = addr - CFG_BASE;
    idx_o        = off[IDX_W+1:2];
    sel_o.is_ctrl = (addr == CTRL_ADDR);
    sel_o.is_cfg  = (addr[1:0] == 2'b00) && (addr >= CFG_BASE) &&
                    ({1'b0, addr} < CFG_END);
  end
endmodule

// File: rtl/dbc_commit_ctrl.sv
module dbc_commit_ctrl
  import dbc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl_i,
  input  logic wr_load_i,
  input  logic wr_autodis_i,
  input  logic vb_rise_i,
  output logic load_q,
  output logic autodis_q,
  output logic xfer_o
);
  logic set_req, ctrl_en, load_d, autodis_d;

  always_comb begin
    set_req   = wr_ctrl_i & wr_load_i;
    xfer_o    = vb_rise_i & (load_q | ~autodis_q);
    ctrl_en   = wr_ctrl_i | xfer_o;
    if (set_req)     load_d = 1'b1;
    else if (xfer_o) load_d = 1'b0;
    else             load_d = load_q;
    autodis_d = wr_ctrl_i ? wr_autodis_i : autodis_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q    <= 1'b0;
      autodis_q <= 1'b1;
    end else if (ctrl_en) begin
      load_q    <= load_d;
      autodis_q <= autodis_d;
    end
  end

  // R8: a request written in any cycle, even the transfer cycle, is kept
  assert_req_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl_i && wr_load_i) |=> load_q);

  // R5: a served request clears itself
  assert_req_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q && vb_rise_i && !wr_ctrl_i) |=> !load_q);

  // R3: no blanking start, no change of the request bit unless written
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!vb_rise_i && !wr_ctrl_i) |=> $stable(load_q));
endmodule

// File: rtl/dbc_reg_bank.sv
module dbc_reg_bank #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_cfg_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic                             xfer_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  shadow_q,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  active_q
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    logic sh_en;
    always_comb sh_en = wr_cfg_i && (idx_i == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     shadow_q[i] <= '0;
      else if (sh_en) shadow_q[i] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      active_q[i] <= '0;
      else if (xfer_i) active_q[i] <= shadow_q[i];
    end
  end

  // R3: the active copy moves only on a transfer
  assert_active_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_i |=> $stable(active_q));

  // R4 / R11: a transfer copies the shadow seen in the transfer cycle
  assert_active_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_i |=> (active_q == $past(shadow_q)));
endmodule

// File: rtl/dbc_top.sv
module dbc_top
  import dbc_pkg::*;
#(
  parameter int              NUM_REGS    = 8,
  parameter int              DATA_W      = 32,
  parameter int              ADDR_W      = 15,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] CFG_BASE  = 15'h0800,
  localparam int             IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       vblank_i,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] active_cfg,
  output logic                       commit_pulse
);
  dbc_sel_t                         sel;
  logic [IDX_W-1:0]                 idx;
  logic                             vb_rise, xfer, load_q, autodis_q;
  logic [NUM_REGS-1:0][DATA_W-1:0]  shadow, active;

  dbc_vblank_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .vblank_i(vblank_i), .rise_o(vb_rise));

  dbc_addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
                    .CTRL_ADDR(CTRL_ADDR), .CFG_BASE(CFG_BASE)) u_dec (
    .addr(addr), .sel_o(sel), .idx_o(idx));

  dbc_commit_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl_i(wr_en & sel.is_ctrl),
    .wr_load_i(wr_data[CTRL_LOAD_BIT]),
    .wr_autodis_i(wr_data[CTRL_AUTODIS_BIT]),
    .vb_rise_i(vb_rise),
    .load_q(load_q), .autodis_q(autodis_q), .xfer_o(xfer));

  dbc_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_cfg_i(wr_en & sel.is_cfg), .idx_i(idx), .wdata_i(wr_data),
    .xfer_i(xfer), .shadow_q(shadow), .active_q(active));

  always_comb begin
    rd_data = '0;
    if (sel.is_ctrl) begin
      rd_data[CTRL_LOAD_BIT]    = load_q;
      rd_data[CTRL_AUTODIS_BIT] = autodis_q;
    end else if (sel.is_cfg) begin
      rd_data = shadow[idx];
    end
  end

  assign active_cfg   = active;
  assign commit_pulse = xfer;

  // R1: right after reset nothing is pending and nothing is active
  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (active_cfg == '0) && !commit_pulse);
endmodule

// File: tb/test_dbc_top.sv
module test_dbc_top;
  localparam int NR = 8;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              vblank_i = 1'b0;
  logic              wr_en = 1'b0;
  logic [14:0]       addr = '0;
  logic [31:0]       wr_data = '0;
  logic [31:0]       rd_data;
  logic [NR*32-1:0]  active_cfg;
  logic              commit_pulse;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dbc_top i_dbc_top (
    .clk(clk), .rst_n(rst_n), .vblank_i(vblank_i), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .active_cfg(active_cfg), .commit_pulse(commit_pulse));

  localparam logic [14:0] T_ADDR [0:7] = '{15'h0800, 15'h0804, 15'h081C, 15'h0802,
                                           15'h0820, 15'h0004, 15'h0808, 15'h07FC};
  localparam logic [31:0] T_DATA [0:7] = '{32'hA5A5_0001, 32'h1234_5678, 32'hDEAD_BEEF, 32'hFFFF_FFFF,
                                           32'h5555_5555, 32'h7777_7777, 32'h0000_00C3, 32'h9999_9999};
  localparam logic [31:0] T_EXP  [0:7] = '{32'hA5A5_0001, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0,
                                           32'h0, 32'h0, 32'h0000_00C3, 32'h0};

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [14:0] a, output logic [31:0] d);
    addr = a; #1; d = rd_data;
  endtask

  function automatic logic [31:0] act_word(input int i);
    return active_cfg[i*32 +: 32];
  endfunction

  task automatic vb_up();
    vblank_i = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic vb_down();
    vblank_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(15'h0000, r); check(r, 32'h2, "R1 control word");
    check(active_cfg[31:0], 32'h0, "R1 active word 0");
    check({31'b0, commit_pulse}, 32'h0, "R1 commit_pulse");
    rd(15'h0800, r); check(r, 32'h0, "R1 shadow word 0");

    // R2 / R10 table walk
    for (int k = 0; k < 8; k++) begin
      wr(T_ADDR[k], T_DATA[k]);
      rd(T_ADDR[k], r);
      check(r, T_EXP[k], "R2/R10 readback");
      check(act_word(0) | act_word(1) | act_word(7), 32'h0, "R2 active untouched");
    end
    rd(15'h0800, r); check(r, 32'hA5A5_0001, "R10 misaligned write ignored");
    rd(15'h0000, r); check(r, 32'h2, "R10 unused write left control");

    // R3 blanking without request
    vb_up();
    check({31'b0, commit_pulse}, 32'h0, "R3 no pulse");
    @(negedge clk);
    check(act_word(0), 32'h0, "R3 active unchanged");
    vb_down();

    // R4 / R5 manual request
    wr(15'h0000, 32'h3);
    rd(15'h0000, r); check(r, 32'h3, "R5 request reads set");
    vb_up();
    check({31'b0, commit_pulse}, 32'h1, "R4 pulse timing");
    check(act_word(0), 32'h0, "R4 not yet copied");
    rd(15'h0000, r); check(r, 32'h3, "R5 still set before transfer");
    @(negedge clk);
    check({31'b0, commit_pulse}, 32'h0, "R4 pulse one cycle");
    check(act_word(0), 32'hA5A5_0001, "R4 word 0 copied");
    check(act_word(7), 32'hDEAD_BEEF, "R4 word 7 copied");
    rd(15'h0000, r); check(r, 32'h2, "R5 self cleared");

    // R7 held-high level and falling edge
    wr(15'h0800, 32'h0000_1111);
    repeat (5) begin
      @(negedge clk);
      check({31'b0, commit_pulse}, 32'h0, "R7 no repeat while high");
    end
    vb_down();
    check(act_word(0), 32'hA5A5_0001, "R7 no transfer on fall");

    // R9 writing 0 does not withdraw the request
    wr(15'h0000, 32'h3);
    wr(15'h0000, 32'h2);
    rd(15'h0000, r); check(r, 32'h3, "R9 request kept");
    vb_up(); @(negedge clk);
    check(act_word(0), 32'h0000_1111, "R9 request served");
    vb_down();

    // R8 request written in the transfer cycle
    wr(15'h0000, 32'h3);
    wr(15'h0800, 32'h0000_2222);
    vb_up();
    wr(15'h0000, 32'h3);
    check(act_word(0), 32'h0000_2222, "R8 first transfer");
    rd(15'h0000, r); check(r, 32'h3, "R8 request kept");
    vb_down();

    // R11 shadow write in the transfer cycle
    wr(15'h0800, 32'h0000_3333);
    vb_up();
    wr(15'h0800, 32'h0000_4444);
    check(act_word(0), 32'h0000_3333, "R11 active takes old shadow");
    rd(15'h0800, r); check(r, 32'h0000_4444, "R11 shadow takes new");
    rd(15'h0000, r); check(r, 32'h2, "R8 pending request served");
    vb_down();

    // R6 automatic mode
    wr(15'h0000, 32'h0);
    wr(15'h0804, 32'h0000_D00D);
    vb_up(); @(negedge clk);
    check(act_word(1), 32'h0000_D00D, "R6 automatic transfer 1");
    vb_down();
    wr(15'h0804, 32'h0000_E00E);
    vb_up(); @(negedge clk);
    check(act_word(1), 32'h0000_E00E, "R6 automatic transfer 2");
    rd(15'h0000, r); check(r, 32'h0, "R6 control word");
    vb_down();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule